// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block performs the single-cycle state update that moves a processor core into an exception handler. The pipeline presents a pending exception code. Two interrupt request lines, one external and one from the timer, are presented alongside it. The block also sees a read-only view of the current architectural state: program counter, status word, power-management word, vector base register, the vector-base-enable configuration bit and the delay-slot flag. When the entry strobe is high, the block picks the cause and registers the full set of updated values on that clock edge. These values are the new program counter (the handler vector), the new status word, the saved status word, the saved return address, the effective-address register and the new power-management word.

The registered outputs are written into the core's state by the surrounding logic. The block raises `commit_o` for one cycle when they are valid. That same pulse tells the core to clear its delay-slot flag and to set its load-reserve lock address to all ones. When an unusable cause reaches the block, it raises `abort_o` instead and leaves every state output unchanged. The strobe and all pulses are plain control pins. An entry is a single-edge transaction with no data stream to pace, so there is no valid/ready pair and no back-pressure: the core must be able to take `commit_o` on any cycle.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `commit_o`, `abort_o`, `taken_o` and `eear_we_o` are 0. `sr_o` equals 1 (only the supervisor bit 0 set). `pc_o`, `esr_o`, `epcr_o`, `eear_o` and `pmr_o` are 0.
- R2: `entry_i` high with a usable cause at one clock edge makes `commit_o` 1 for the following cycle only. With `entry_i` low, no pulse rises and every state output holds its value.
- R3: A nonzero `exc_code_i` is always the cause and gives `taken_o`=0. When `exc_code_i` is 0, the cause is the timer (code 5) if `irq_tmr_i` is high and `sr_i` bit 1 is set. Otherwise it is the external interrupt (code 8) if `irq_ext_i` is high and `sr_i` bit 2 is set. An interrupt-chosen cause gives `taken_o`=1 together with `commit_o`.
- R4: `epcr_o` equals `pc_i`, minus 4 when `dflag_i` is high, and then plus 4 when the cause is the system call (code 12).
- R5: For the illegal-instruction cause (code 7), `eear_o` takes `pc_i` and `eear_we_o` pulses with `commit_o`. For any other cause, `eear_o` keeps its value and `eear_we_o` stays 0.
- R6: First, `sr_i` is taken with bit 13 (delay-slot record) replaced by `dflag_i`. `esr_o` takes this word. `sr_o` takes the same word with bits 1, 2, 5 and 6 cleared and bit 0 set.
- R7: `pmr_o` takes `pmr_i` with bits 4 and 5 cleared and all other bits unchanged.
- R8: `pc_o` equals the cause code shifted left by 8. It is ORed with `evbar_i` when `evbar_en_i` is high, and ORed with 0xF0000000 when `sr_i` bit 14 is set.
- R9: A cause of 0 after selection, or a cause of 15, gives `abort_o`=1 for one cycle with `commit_o`=0. In that case every state output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| entry_i | input | 1 | Entry strobe, sampled on the rising edge |
| exc_code_i | input | 4 | Pending exception code from the pipeline, 0 when none |
| irq_ext_i | input | 1 | External interrupt request |
| irq_tmr_i | input | 1 | Timer interrupt request |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 32 | Current status word |
| pmr_i | input | 32 | Current power-management word |
| evbar_i | input | 32 | Vector base address |
| evbar_en_i | input | 1 | Configuration: apply vector base |
| dflag_i | input | 1 | Current instruction sits in a delay slot |
| pc_o | output | 32 | Handler vector (new program counter) |
| sr_o | output | 32 | New status word |
| esr_o | output | 32 | Saved status word |
| epcr_o | output | 32 | Saved return address |
| eear_o | output | 32 | Effective-address register |
| pmr_o | output | 32 | New power-management word |
| eear_we_o | output | 1 | Effective-address register was loaded this entry |
| commit_o | output | 1 | Updated state valid; core clears delay-slot flag and lock |
| taken_o | output | 1 | Entry was caused by an interrupt request |
| abort_o | output | 1 | Unusable cause; nothing updated |

## Verification
Several invariants are checked on every cycle. A commit always leaves the core in supervisor mode with both interrupt enables and both mode bits cleared, and the two power-management bits cleared. The handler vector is aligned to 256 bytes. The saved and new status words agree on the delay-slot record. An abort never coincides with a commit and never moves the state outputs. A quiet strobe produces no pulse. Other properties depend on the combination of inputs and can only be shown by the bench's scenarios: the exact return address for delay-slot and system-call combinations, timer-over-external priority, exceptions beating interrupts, and the vector base and high-page OR.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [3:0] {
    EXC_NONE    = 4'd0,
    EXC_RESET   = 4'd1,
    EXC_BUSERR  = 4'd2,
    EXC_DPAGE   = 4'd3,
    EXC_IPAGE   = 4'd4,
    EXC_TICK    = 4'd5,
    EXC_ALIGN   = 4'd6,
    EXC_ILLEGAL = 4'd7,
    EXC_EXTINT  = 4'd8,
    EXC_DTLB    = 4'd9,
    EXC_ITLB    = 4'd10,
    EXC_RANGE   = 4'd11,
    EXC_SYSCALL = 4'd12,
    EXC_FPE     = 4'd13,
    EXC_TRAP    = 4'd14
  } exc_code_e;

  // status word bit positions
  localparam int unsigned SR_SUPV   = 0;
  localparam int unsigned SR_TMR_EN = 1;
  localparam int unsigned SR_IRQ_EN = 2;
  localparam int unsigned SR_DMMU   = 5;
  localparam int unsigned SR_IMMU   = 6;
  localparam int unsigned SR_DSLOT  = 13;
  localparam int unsigned SR_HIPAGE = 14;

  // power-management word bit positions
  localparam int unsigned PM_DOZE   = 4;
  localparam int unsigned PM_SLEEP  = 5;

  localparam int unsigned INSN_BYTES = 4;

endpackage

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
  import exc_entry_pkg::*;
#(
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned NUM_EXC = 15
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              irq_ext_i,
  input  logic              irq_tmr_i,
  input  logic              irq_en_i,
  input  logic              tmr_en_i,
  output logic [CODE_W-1:0] code_o,
  output logic              from_irq_o,
  output logic              usable_o
);

  logic ext_ok;
  logic tmr_ok;

  assign ext_ok = irq_ext_i & irq_en_i;
  assign tmr_ok = irq_tmr_i & tmr_en_i;

  always_comb begin
    code_o     = code_i;
    from_irq_o = 1'b0;
    if (code_i == '0) begin
      if (tmr_ok) begin
        code_o     = CODE_W'(EXC_TICK);
        from_irq_o = 1'b1;
      end else if (ext_ok) begin
        code_o     = CODE_W'(EXC_EXTINT);
        from_irq_o = 1'b1;
      end
    end
  end

  assign usable_o = (code_o != '0) && (32'(code_o) < NUM_EXC);

  // R3: an interrupt-chosen cause is always usable
  always_comb begin
    a_r3_irq_cause_usable: assert (!from_irq_o || usable_o);
  end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned VEC_SHIFT = 8,
  parameter int unsigned HI_BITS   = 4
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic              base_en_i,
  input  logic              hipage_i,
  output logic [XLEN-1:0]   vec_o
);

  localparam logic [XLEN-1:0] HI_MASK = {{HI_BITS{1'b1}}, {(XLEN-HI_BITS){1'b0}}};

  logic [XLEN-1:0] offset;

  assign offset = XLEN'(code_i) << VEC_SHIFT;

  assign vec_o = offset
               | (base_en_i ? base_i  : '0)
               | (hipage_i  ? HI_MASK : '0);

endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 4
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pmr_i,
  input  logic              dflag_i,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   esr_o,
  output logic [XLEN-1:0]   pmr_o,
  output logic [XLEN-1:0]   epcr_o,
  output logic              illegal_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] sr_marked;
  logic [XLEN-1:0] ret_base;
  logic            is_syscall;

  always_comb begin
    sr_marked           = sr_i;
    sr_marked[SR_DSLOT] = dflag_i;
  end

  always_comb begin
    sr_o            = sr_marked;
    sr_o[SR_DMMU]   = 1'b0;
    sr_o[SR_IMMU]   = 1'b0;
    sr_o[SR_IRQ_EN] = 1'b0;
    sr_o[SR_TMR_EN] = 1'b0;
    sr_o[SR_SUPV]   = 1'b1;
  end

  always_comb begin
    pmr_o           = pmr_i;
    pmr_o[PM_DOZE]  = 1'b0;
    pmr_o[PM_SLEEP] = 1'b0;
  end

  assign esr_o      = sr_marked;
  assign is_syscall = (code_i == CODE_W'(EXC_SYSCALL));
  assign illegal_o  = (code_i == CODE_W'(EXC_ILLEGAL));
  assign ret_base   = dflag_i ? (pc_i - STEP) : pc_i;
  assign epcr_o     = is_syscall ? (ret_base + STEP) : ret_base;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned NUM_EXC   = 15,
  parameter int unsigned VEC_SHIFT = 8,
  parameter int unsigned HI_BITS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              entry_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_ext_i,
  input  logic              irq_tmr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pmr_i,
  input  logic [XLEN-1:0]   evbar_i,
  input  logic              evbar_en_i,
  input  logic              dflag_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   esr_o,
  output logic [XLEN-1:0]   epcr_o,
  output logic [XLEN-1:0]   eear_o,
  output logic [XLEN-1:0]   pmr_o,
  output logic              eear_we_o,
  output logic              commit_o,
  output logic              taken_o,
  output logic              abort_o
);

  localparam logic [XLEN-1:0] SR_RESET = XLEN'(1) << SR_SUPV;

  logic [CODE_W-1:0] cause;
  logic              cause_irq;
  logic              cause_ok;
  logic [XLEN-1:0]   vec_n;
  logic [XLEN-1:0]   sr_n;
  logic [XLEN-1:0]   esr_n;
  logic [XLEN-1:0]   pmr_n;
  logic [XLEN-1:0]   epcr_n;
  logic              illegal_n;

  exc_cause_sel #(
    .CODE_W  (CODE_W),
    .NUM_EXC (NUM_EXC)
  ) u_sel (
    .code_i     (exc_code_i),
    .irq_ext_i  (irq_ext_i),
    .irq_tmr_i  (irq_tmr_i),
    .irq_en_i   (sr_i[SR_IRQ_EN]),
    .tmr_en_i   (sr_i[SR_TMR_EN]),
    .code_o     (cause),
    .from_irq_o (cause_irq),
    .usable_o   (cause_ok)
  );

  exc_vector_gen #(
    .XLEN      (XLEN),
    .CODE_W    (CODE_W),
    .VEC_SHIFT (VEC_SHIFT),
    .HI_BITS   (HI_BITS)
  ) u_vec (
    .code_i    (cause),
    .base_i    (evbar_i),
    .base_en_i (evbar_en_i),
    .hipage_i  (sr_i[SR_HIPAGE]),
    .vec_o     (vec_n)
  );

  exc_state_calc #(
    .XLEN   (XLEN),
    .CODE_W (CODE_W)
  ) u_calc (
    .code_i    (cause),
    .pc_i      (pc_i),
    .sr_i      (sr_i),
    .pmr_i     (pmr_i),
    .dflag_i   (dflag_i),
    .sr_o      (sr_n),
    .esr_o     (esr_n),
    .pmr_o     (pmr_n),
    .epcr_o    (epcr_n),
    .illegal_o (illegal_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o      <= '0;
      sr_o      <= SR_RESET;
      esr_o     <= '0;
      epcr_o    <= '0;
      eear_o    <= '0;
      pmr_o     <= '0;
      eear_we_o <= 1'b0;
      commit_o  <= 1'b0;
      taken_o   <= 1'b0;
      abort_o   <= 1'b0;
    end else begin
      eear_we_o <= 1'b0;
      commit_o  <= 1'b0;
      taken_o   <= 1'b0;
      abort_o   <= 1'b0;
      if (entry_i) begin
        if (cause_ok) begin
          pc_o      <= vec_n;
          sr_o      <= sr_n;
          esr_o     <= esr_n;
          epcr_o    <= epcr_n;
          pmr_o     <= pmr_n;
          commit_o  <= 1'b1;
          taken_o   <= cause_irq;
          eear_we_o <= illegal_n;
          if (illegal_n) begin
            eear_o <= pc_i;
          end
        end else begin
          abort_o <= 1'b1;
        end
      end
    end
  end

  // R2: a quiet strobe raises no pulse
  a_r2_quiet_strobe: assert property (@(posedge clk) disable iff (rst)
    !entry_i |=> (!commit_o && !abort_o));

  // R9: unusable cause aborts without committing
  a_r9_bad_cause_aborts: assert property (@(posedge clk) disable iff (rst)
    (entry_i && !cause_ok) |=> (abort_o && !commit_o));

  // R9: an abort leaves the state untouched
  a_r9_abort_holds: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> ($stable(pc_o) && $stable(sr_o) && $stable(epcr_o) && $stable(eear_o)));

  // R6: supervisor entry with enables and mode bits cleared
  a_r6_supervisor_entry: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> (sr_o[SR_SUPV] && !sr_o[SR_IRQ_EN] && !sr_o[SR_TMR_EN]
                  && !sr_o[SR_DMMU] && !sr_o[SR_IMMU]));

  // R6: saved and new status agree on the delay-slot record
  a_r6_dslot_agree: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> (esr_o[SR_DSLOT] == sr_o[SR_DSLOT]));

  // R7: power-saving bits cleared on commit
  a_r7_pm_cleared: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> (!pmr_o[PM_DOZE] && !pmr_o[PM_SLEEP]));

  // R8: handler vector aligned to the slot size
  a_r8_vec_aligned: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> (pc_o[VEC_SHIFT-1:0] == '0));

  // R3: interrupt flag only with a commit
  a_r3_taken_commits: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> commit_o);

  // R5: effective address captured from the entry PC
  a_r5_eear_capture: assert property (@(posedge clk) disable iff (rst)
    eear_we_o |-> (commit_o && eear_o == $past(pc_i)));

endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] sr;
    logic [31:0] esr;
    logic [31:0] epcr;
    logic [31:0] eear;
    logic [31:0] pmr;
    logic        we;
    logic        commit;
    logic        taken;
    logic        abort;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        entry_i = 1'b0;
  logic [3:0]  exc_code_i = '0;
  logic        irq_ext_i = 1'b0;
  logic        irq_tmr_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic [31:0] sr_i = '0;
  logic [31:0] pmr_i = '0;
  logic [31:0] evbar_i = '0;
  logic        evbar_en_i = 1'b0;
  logic        dflag_i = 1'b0;
  logic [31:0] pc_o, sr_o, esr_o, epcr_o, eear_o, pmr_o;
  logic        eear_we_o, commit_o, taken_o, abort_o;

  int   n_checks = 0;
  int   n_fail   = 0;
  exp_t held;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  exc_entry_ctrl uut (
    .clk(clk), .rst(rst), .entry_i(entry_i), .exc_code_i(exc_code_i),
    .irq_ext_i(irq_ext_i), .irq_tmr_i(irq_tmr_i), .pc_i(pc_i), .sr_i(sr_i),
    .pmr_i(pmr_i), .evbar_i(evbar_i), .evbar_en_i(evbar_en_i), .dflag_i(dflag_i),
    .pc_o(pc_o), .sr_o(sr_o), .esr_o(esr_o), .epcr_o(epcr_o), .eear_o(eear_o),
    .pmr_o(pmr_o), .eear_we_o(eear_we_o), .commit_o(commit_o), .taken_o(taken_o),
    .abort_o(abort_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // expected outputs derived from the requirement text
  function automatic exp_t predict(input exp_t prev, input logic [3:0] code,
                                   input logic ext, input logic tmr, input logic [31:0] pc,
                                   input logic [31:0] sr, input logic [31:0] pmr,
                                   input logic [31:0] base, input logic base_en,
                                   input logic ds);
    exp_t e = prev;
    logic [3:0] c = code;
    logic irq = 1'b0;
    logic [31:0] marked;
    e.we = 0; e.commit = 0; e.taken = 0; e.abort = 0;
    if (c == 0 && tmr && sr[1]) begin c = 4'd5; irq = 1; end
    else if (c == 0 && ext && sr[2]) begin c = 4'd8; irq = 1; end
    if (c == 0 || c == 4'd15) begin
      e.abort = 1;
      return e;
    end
    marked = sr; marked[13] = ds;
    e.esr  = marked;
    e.sr   = (marked & ~32'h0000_0066) | 32'h1;
    e.pmr  = pmr & ~32'h0000_0030;
    e.epcr = pc - (ds ? 32'd4 : 32'd0) + ((c == 4'd12) ? 32'd4 : 32'd0);
    if (c == 4'd7) begin e.eear = pc; e.we = 1; end
    e.pc = {24'h0, c, 8'h0} | (base_en ? base : 32'h0) | (sr[14] ? 32'hF000_0000 : 32'h0);
    e.commit = 1;
    e.taken  = irq;
    return e;
  endfunction

  exp_t tail_state;

  task automatic launch(input logic [3:0] code, input logic ext, input logic tmr,
                        input logic [31:0] pc, input logic [31:0] sr, input logic [31:0] pmr,
                        input logic [31:0] base, input logic base_en, input logic ds);
    exp_t e;
    @(negedge clk);
    exc_code_i = code; irq_ext_i = ext; irq_tmr_i = tmr; pc_i = pc; sr_i = sr;
    pmr_i = pmr; evbar_i = base; evbar_en_i = base_en; dflag_i = ds; entry_i = 1'b1;
    e = predict(tail_state, code, ext, tmr, pc, sr, pmr, base, base_en, ds);
    tail_state = e;
    sb_q.push_back(e);
    @(negedge clk);
    entry_i = 1'b0;
    #1;
    n_checks++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 no response to entry: actual pending=%0d expected=0", sb_q.size());
      sb_q.delete();
    end
  endtask

  // monitor: pops the scoreboard on every pulse, otherwise expects held state
  always @(negedge clk) begin
    if (!rst) begin
      exp_t e;
      if (commit_o || abort_o) begin
        if (sb_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R2 unexpected pulse: actual=1 expected=0");
          e = held;
        end else begin
          e = sb_q.pop_front();
        end
      end else begin
        e = held;
        e.we = 0; e.commit = 0; e.taken = 0; e.abort = 0;
      end
      chk("R8 pc_o",      pc_o,   e.pc);
      chk("R6 sr_o",      sr_o,   e.sr);
      chk("R6 esr_o",     esr_o,  e.esr);
      chk("R4 epcr_o",    epcr_o, e.epcr);
      chk("R5 eear_o",    eear_o, e.eear);
      chk("R7 pmr_o",     pmr_o,  e.pmr);
      chk("R5 eear_we_o", 32'(eear_we_o), 32'(e.we));
      chk("R2 commit_o",  32'(commit_o),  32'(e.commit));
      chk("R3 taken_o",   32'(taken_o),   32'(e.taken));
      chk("R9 abort_o",   32'(abort_o),   32'(e.abort));
      held = e;
    end
  end

  initial begin
    held = '0;
    held.sr = 32'h1;   // R1 reset state: only supervisor bit
    tail_state = held;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 sr_o in reset", sr_o, 32'h1);
    chk("R1 pulses in reset", {28'h0, eear_we_o, commit_o, taken_o, abort_o}, 32'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);   // R1/R2 idle hold checked by monitor

    // R2 R8: plain bus error
    launch(4'd2, 0, 0, 32'h0000_1000, 32'h0000_0006, 32'h0, 32'h0, 0, 0);
    repeat (2) @(negedge clk);
    // R4 R6: alignment in a delay slot
    launch(4'd6, 0, 0, 32'h0000_2008, 32'h0000_0067, 32'h0, 32'h0, 0, 1);
    // R4: system call, with and without delay slot
    launch(4'd12, 0, 0, 32'h0000_3000, 32'h0, 32'h0, 32'h0, 0, 1);
    launch(4'd12, 0, 0, 32'h0000_3010, 32'h0, 32'h0, 32'h0, 0, 0);
    // R5: illegal captures address, then another cause leaves it
    launch(4'd7, 0, 0, 32'h0000_4444, 32'h0, 32'h0, 32'h0, 0, 0);
    launch(4'd3, 0, 0, 32'h0000_5550, 32'h0, 32'h0, 32'h0, 0, 0);
    // R8: vector base and high page
    launch(4'd9, 0, 0, 32'h0000_0100, 32'h0000_4000, 32'h0, 32'h0001_0000, 1, 0);
    launch(4'd14, 0, 0, 32'h0000_0100, 32'h0, 32'h0, 32'h0002_0000, 1, 0);
    launch(4'd1, 0, 0, 32'h0, 32'h0000_4000, 32'h0, 32'h0003_0000, 0, 0);
    // R7 R6: all-ones status and power words
    launch(4'd13, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 0, 0);
    // R3: interrupt selection
    launch(4'd0, 1, 0, 32'h0000_6000, 32'h0000_0004, 32'h0, 32'h0, 0, 0);
    launch(4'd0, 1, 1, 32'h0000_6004, 32'h0000_0006, 32'h0, 32'h0, 0, 0);
    launch(4'd0, 1, 1, 32'h0000_6008, 32'h0000_0004, 32'h0, 32'h0, 0, 0);
    launch(4'd0, 0, 1, 32'h0000_600C, 32'h0000_0002, 32'h0, 32'h0, 0, 1);
    // R3: exception beats pending interrupts
    launch(4'd11, 1, 1, 32'h0000_7000, 32'h0000_0006, 32'h0, 32'h0, 0, 0);
    // R9: requests with enables off, no cause, and code 15
    launch(4'd0, 1, 1, 32'h0000_8000, 32'h0000_0000, 32'h0, 32'h0, 0, 0);
    launch(4'd0, 0, 0, 32'h0000_8004, 32'h0000_0006, 32'h0, 32'h0, 0, 0);
    launch(4'd15, 0, 0, 32'h0000_8008, 32'h0000_0006, 32'hFF, 32'h0, 1, 1);
    // R2: quiet cycles with busy inputs hold everything
    @(negedge clk);
    exc_code_i = 4'd7; irq_ext_i = 1; irq_tmr_i = 1; sr_i = 32'hFFFF_FFFF; pc_i = 32'h1234_5678;
    repeat (4) @(negedge clk);
    launch(4'd10, 0, 0, 32'h0000_9000, 32'h0, 32'h0, 32'h0, 0, 0);
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule